// File: doc/BRIEF.md
# Prescaled Fractional Bit-Rate Generator

This block turns the system clock into the timing ticks that a serial bus bit engine uses to shape its clock and data lines. An integer prescaler first divides the system clock by a value from 1 to 256 and produces a kernel tick. A fractional accumulator then turns kernel ticks into time-quantum ticks. The quantum ticks have an average spacing of exactly `frac_mod_i / frac_step_i` kernel ticks, so the rate does not have to be an integer ratio.

The quanta are grouped into a bit period with a configurable low phase and a configurable high phase. Inside the low phase, a data-change tick marks the point where the data line may be driven, a number of quanta after the falling clock edge. Inside the high phase, a sample tick marks the data sampling point. The prescaler alone spans low system clocks. The fractional step covers the range of bit rates that is used, from 20 kbit/s up to 3.4 Mbit/s; with a divide of 1 and step equal to the modulus, the block gives one quantum per system clock.

All configuration is captured while `en_i` is low and is frozen while the generator runs.

Top module: `bitrate_gen`

## Requirements
- R1: While enabled, `kclk_o` pulses for one cycle every `pre_div_i + 1` system cycles. The first pulse is visible after clock edge `pre_div_i`, counting the first edge with `en_i` high as edge 0. A prescale value of 0 therefore means a pulse every cycle.
- R2: On the m-th kernel tick since enable (m = 1, 2, ...), `tq_o` pulses together with `kclk_o` exactly when floor(m*step/mod) exceeds floor((m-1)*step/mod). This holds for 1 <= mod and step <= mod. A step of 0 gives no quantum ticks.
- R3: Over any run of m kernel ticks from enable, the number of `tq_o` pulses is floor(m*step/mod).
- R4: `scl_o` is 0 for the first `low_len_i` quanta of each bit period and 1 for the next `high_len_i` quanta. A period starts low at enable. A length of 0 acts as 1.
- R5: `fall_o` pulses in the cycle where `scl_o` changes from 1 to 0, and `rise_o` pulses where it changes from 0 to 1. The two never pulse together.
- R6: `data_o` pulses when a quantum tick enters low-phase quantum index `hold_len_i`, with index 0 at the fall. It never pulses when `hold_len_i` is at or beyond the effective low length.
- R7: `smp_o` pulses when a quantum tick enters high-phase quantum index `smp_len_i`, with index 0 at the rise. It never pulses when `smp_len_i` is at or beyond the effective high length.
- R8: The configuration inputs are captured only while `en_i` is low. Changing them while enabled has no effect on any output.
- R9: After reset, and one cycle after `en_i` goes low, all outputs are 0 and the prescaler, the accumulator and the phase position restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; configuration is loaded while low |
| pre_div_i | input | 8 | Prescale value, divide by value+1 |
| frac_step_i | input | 16 | Accumulator increment per kernel tick |
| frac_mod_i | input | 16 | Accumulator modulus |
| low_len_i | input | 8 | Low phase length in quanta |
| high_len_i | input | 8 | High phase length in quanta |
| hold_len_i | input | 8 | Data-change offset into the low phase, in quanta |
| smp_len_i | input | 8 | Sample offset into the high phase, in quanta |
| kclk_o | output | 1 | Kernel tick pulse |
| tq_o | output | 1 | Time-quantum tick pulse |
| scl_o | output | 1 | Bus clock level, 1 in the high phase |
| fall_o | output | 1 | Pulse at the start of the low phase |
| rise_o | output | 1 | Pulse at the start of the high phase |
| data_o | output | 1 | Data-change point pulse |
| smp_o | output | 1 | Sample point pulse |

## Verification
The assertions check on every cycle that the prescaler count stays within the prescale value and that the accumulator remainder stays below the modulus. They also check that a quantum tick only comes with a kernel tick, that rise and fall never coincide, that the frozen configuration holds while running and that a disabled generator is quiet. Only the bench scenarios can show the exact spacing of ticks for a given prescale and fraction, the long-run count of quanta, and the placement of data-change and sample points within each phase. They also show that zero and oversize phase settings behave as specified and that configuration changes made mid-run are ignored.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned PRE_W_D = 8;
  localparam int unsigned ACC_W_D = 16;
  localparam int unsigned LEN_W_D = 8;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int unsigned PRE_W = brg_pkg::PRE_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             ken_o
);
  logic [PRE_W-1:0] cnt_q;

  assign ken_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (ken_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end

  AST_PCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i)); // R1
endmodule

// File: rtl/brg_frac_div.sv
module brg_frac_div #(
  parameter int unsigned ACC_W = brg_pkg::ACC_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ken_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [ACC_W-1:0] mod_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   rem;
  logic             wrap;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  assign wrap   = (sum >= {1'b0, mod_i}) && (step_i != '0);
  assign rem    = sum - {1'b0, mod_i};
  assign tick_o = ken_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!run_i) acc_q <= '0;
    else if (ken_i)  acc_q <= wrap ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
  end

  AST_ACC_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mod_i != '0 && step_i <= mod_i) |-> (acc_q < mod_i)); // R3
endmodule

// File: rtl/brg_phase_seq.sv
module brg_phase_seq #(
  parameter int unsigned LEN_W = brg_pkg::LEN_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             qtick_i,
  input  logic [LEN_W-1:0] low_i,
  input  logic [LEN_W-1:0] high_i,
  input  logic [LEN_W-1:0] hold_i,
  input  logic [LEN_W-1:0] smp_i,
  output logic             scl_o,
  output logic             fall_o,
  output logic             rise_o,
  output logic             data_o,
  output logic             smp_o
);
  import brg_pkg::*;

  phase_e           phase_q, phase_n;
  logic [LEN_W-1:0] idx_q, idx_n;
  logic [LEN_W-1:0] low_last, high_last, cur_last;
  logic             at_end;

  assign low_last  = (low_i  == '0) ? '0 : low_i  - LEN_W'(1);
  assign high_last = (high_i == '0) ? '0 : high_i - LEN_W'(1);
  assign cur_last  = (phase_q == PH_LOW) ? low_last : high_last;
  assign at_end    = (idx_q == cur_last);

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    if (qtick_i) begin
      if (at_end) begin
        phase_n = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        idx_n   = '0;
      end else begin
        idx_n   = idx_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      idx_q   <= '0;
      fall_o  <= 1'b0;
      rise_o  <= 1'b0;
      data_o  <= 1'b0;
      smp_o   <= 1'b0;
    end else if (!run_i) begin
      phase_q <= PH_LOW;
      idx_q   <= '0;
      fall_o  <= 1'b0;
      rise_o  <= 1'b0;
      data_o  <= 1'b0;
      smp_o   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      fall_o  <= qtick_i && at_end && (phase_q == PH_HIGH);
      rise_o  <= qtick_i && at_end && (phase_q == PH_LOW);
      data_o  <= qtick_i && (phase_n == PH_LOW)  && (idx_n == hold_i);
      smp_o   <= qtick_i && (phase_n == PH_HIGH) && (idx_n == smp_i);
    end
  end

  assign scl_o = (phase_q == PH_HIGH);

  AST_IDX_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (idx_q <= cur_last)); // R4
  AST_FALL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !scl_o); // R5
  AST_RISE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> scl_o); // R5
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
  parameter int unsigned PRE_W = brg_pkg::PRE_W_D,
  parameter int unsigned ACC_W = brg_pkg::ACC_W_D,
  parameter int unsigned LEN_W = brg_pkg::LEN_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_div_i,
  input  logic [ACC_W-1:0] frac_step_i,
  input  logic [ACC_W-1:0] frac_mod_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic [LEN_W-1:0] hold_len_i,
  input  logic [LEN_W-1:0] smp_len_i,
  output logic             kclk_o,
  output logic             tq_o,
  output logic             scl_o,
  output logic             fall_o,
  output logic             rise_o,
  output logic             data_o,
  output logic             smp_o
);
  localparam int unsigned CFG_W = PRE_W + 2 * ACC_W + 4 * LEN_W;

  logic [PRE_W-1:0] pre_q;
  logic [ACC_W-1:0] step_q, mod_q;
  logic [LEN_W-1:0] low_q, high_q, hold_q, smpl_q;
  logic [CFG_W-1:0] cfg_flat;
  logic             ken, qtick;

  // configuration shadow: transparent while idle, frozen while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      step_q <= '0;
      mod_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      hold_q <= '0;
      smpl_q <= '0;
    end else if (!en_i) begin
      pre_q  <= pre_div_i;
      step_q <= frac_step_i;
      mod_q  <= frac_mod_i;
      low_q  <= low_len_i;
      high_q <= high_len_i;
      hold_q <= hold_len_i;
      smpl_q <= smp_len_i;
    end
  end

  assign cfg_flat = {pre_q, step_q, mod_q, low_q, high_q, hold_q, smpl_q};

  brg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (en_i),
    .div_i (pre_q),
    .ken_o (ken)
  );

  brg_frac_div #(.ACC_W(ACC_W)) u_frac (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (en_i),
    .ken_i (ken),
    .step_i(step_q),
    .mod_i (mod_q),
    .tick_o(qtick)
  );

  brg_phase_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .qtick_i(qtick),
    .low_i  (low_q),
    .high_i (high_q),
    .hold_i (hold_q),
    .smp_i  (smpl_q),
    .scl_o  (scl_o),
    .fall_o (fall_o),
    .rise_o (rise_o),
    .data_o (data_o),
    .smp_o  (smp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kclk_o <= 1'b0;
      tq_o   <= 1'b0;
    end else begin
      kclk_o <= ken;
      tq_o   <= qtick;
    end
  end

  AST_TQ_WITH_KCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tq_o |-> kclk_o); // R2
  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o})); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(cfg_flat)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(kclk_o || tq_o || scl_o || fall_o || rise_o || data_o || smp_o)); // R9
endmodule

// File: tb/bitrate_gen_tb.sv
module bitrate_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  pre_div_i = '0;
  logic [15:0] frac_step_i = '0, frac_mod_i = '0;
  logic [7:0]  low_len_i = '0, high_len_i = '0, hold_len_i = '0, smp_len_i = '0;
  logic        kclk_o, tq_o, scl_o, fall_o, rise_o, data_o, smp_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  bitrate_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .pre_div_i(pre_div_i), .frac_step_i(frac_step_i), .frac_mod_i(frac_mod_i),
    .low_len_i(low_len_i), .high_len_i(high_len_i),
    .hold_len_i(hold_len_i), .smp_len_i(smp_len_i),
    .kclk_o(kclk_o), .tq_o(tq_o), .scl_o(scl_o), .fall_o(fall_o),
    .rise_o(rise_o), .data_o(data_o), .smp_o(smp_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected {kclk, tq, scl, fall, rise, data, smp} after edge n since enable
  function automatic logic [6:0] model(input longint n, input int pre, input int s,
                                       input int md, input int lo, input int hi,
                                       input int hd, input int sp);
    longint d, m, k, kp, le, he, p, pos, np;
    logic ken, tq, scl, fl, rs, dt, sm;
    d   = pre + 1;
    m   = (n + 1) / d;
    ken = ((n + 1) % d) == 0;
    k   = (m * s) / md;
    kp  = (m > 0) ? ((m - 1) * s) / md : 0;
    tq  = ken && (k > kp);
    le  = (lo == 0) ? 1 : lo;
    he  = (hi == 0) ? 1 : hi;
    p   = le + he;
    scl = (k % p) >= le;
    fl = 0; rs = 0; dt = 0; sm = 0;
    if (tq) begin
      pos = (k - 1) % p;
      np  = k % p;
      fl  = (pos == p - 1);
      rs  = (pos == le - 1);
      dt  = (np < le) && (np == hd);
      sm  = (np >= le) && ((np - le) == sp);
    end
    return {ken, tq, scl, fl, rs, dt, sm};
  endfunction

  task automatic run_scn(input int pre, input int s, input int md, input int lo,
                         input int hi, input int hd, input int sp,
                         input int cycles, input bit chg);
    logic [6:0] e;
    int tq_cnt = 0;
    longint mt;
    string px;
    @(negedge clk_i);
    en_i = 1'b0;
    pre_div_i = 8'(pre); frac_step_i = 16'(s); frac_mod_i = 16'(md);
    low_len_i = 8'(lo); high_len_i = 8'(hi); hold_len_i = 8'(hd); smp_len_i = 8'(sp);
    @(negedge clk_i);
    @(negedge clk_i);
    en_i = 1'b1;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk_i);
      px = (chg && n > cycles / 4) ? "R8/" : "";
      e = model(longint'(n), pre, s, md, lo, hi, hd, sp);
      chk({px, "R1 kclk"}, kclk_o, e[6]);
      chk({px, "R2 tq"},   tq_o,   e[5]);
      chk({px, "R4 scl"},  scl_o,  e[4]);
      chk({px, "R5 fall"}, fall_o, e[3]);
      chk({px, "R5 rise"}, rise_o, e[2]);
      chk({px, "R6 data"}, data_o, e[1]);
      chk({px, "R7 smp"},  smp_o,  e[0]);
      if (tq_o) tq_cnt++;
      if (chg && n == cycles / 4) begin
        pre_div_i = pre_div_i + 8'd3; frac_step_i = 16'd1; frac_mod_i = 16'd9;
        low_len_i = 8'd7; high_len_i = 8'd1; hold_len_i = 8'd2; smp_len_i = 8'd0;
      end
    end
    mt = longint'(cycles) / (pre + 1);
    n_chk++;
    if (longint'(tq_cnt) != (mt * s) / md) begin
      n_bad++;
      $display("FAIL R3 quantum count: actual=%0d expected=%0d", tq_cnt, (mt * s) / md);
    end
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R9 idle outputs", |{kclk_o, tq_o, scl_o, fall_o, rise_o, data_o, smp_o}, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pre, md, s, lo, hi, hd, sp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R9 reset outputs", |{kclk_o, tq_o, scl_o, fall_o, rise_o, data_o, smp_o}, 1'b0);
    rst_ni = 1'b1;
    // directed corners
    run_scn(0, 1, 1, 2, 2, 0, 1, 200, 0);     // R1 divide by 1, one quantum per cycle
    run_scn(3, 3, 7, 3, 2, 1, 0, 600, 0);     // R2 non-integer ratio
    run_scn(255, 1, 1, 1, 1, 0, 0, 1600, 0);  // R1 maximum prescale
    run_scn(1, 2, 5, 0, 0, 0, 0, 400, 0);     // R4 zero lengths act as 1
    run_scn(0, 1, 2, 3, 2, 5, 4, 400, 0);     // R6 R7 offsets beyond phase: no pulse
    run_scn(2, 0, 4, 2, 2, 0, 0, 300, 0);     // R2 zero step: no quanta
    run_scn(1, 5, 11, 4, 3, 2, 1, 800, 1);    // R8 mid-run change ignored
    for (int i = 0; i < 8; i++) begin
      pre = $urandom_range(0, 7);
      md  = $urandom_range(1, 20);
      s   = $urandom_range(0, md);
      lo  = $urandom_range(0, 5);
      hi  = $urandom_range(0, 5);
      hd  = $urandom_range(0, 6);
      sp  = $urandom_range(0, 6);
      run_scn(pre, s, md, lo, hi, hd, sp, 500, (i % 2) == 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule